// File: doc/BRIEF.md
# Interrupt Line Capture Bank

This block turns a group of raw interrupt request wires into a vector of pending flags that a downstream arbiter can read. Each line is set up by software as either edge-sensitive or level-sensitive, and the two kinds follow different rules for setting and clearing. An edge line remembers a rising request until software or an arbiter acknowledge clears it. A level line follows its request wire: it becomes pending while the wire is high and clears when the wire falls.

Software reaches the block through a small register port with three word addresses: the pending vector (address 0), a software trigger (address 1) and the sense configuration (address 2). The arbiter returns the number of a line it has granted through an acknowledge strobe. The block drives the pending vector, the raw inputs as sampled on the last clock, and a one-cycle pulse whenever new pending bits appear, so the arbiter knows to re-evaluate. Prioritising, masking and CPU signalling belong to other blocks.

Top module: `irq_capture_bank`

## Requirements
- R1: After reset the pending vector, the sampled raw vector, the sense configuration and the new-pending pulse are all zero, and so every line starts as edge-sensitive.
- R2: `raw_o` shows `irq_in` as sampled on the previous rising clock edge. A write to address 2 loads the sense configuration (bit = 1 means level-sensitive, bit = 0 means edge-sensitive), and a read of address 2 returns it.
- R3: An edge line becomes pending on the clock edge where its input is seen high after having been sampled low, and it stays pending when its input falls again.
- R4: An edge line whose input stays high does not become pending again after its pending bit was cleared; only a new low-to-high transition sets it again.
- R5: A level line becomes pending on any clock edge where its input is high, and its pending bit clears on the clock edge where its input is first seen low after having been high.
- R6: A write to address 0 keeps each pending bit whose data bit is 1 and clears each bit whose data bit is 0, except on a level line whose input is high at that edge, which stays pending. A read of address 0 returns the pending vector.
- R7: A write to address 1 makes pending only the lowest-numbered line whose data bit is 1, whatever its sense; the other set bits are ignored, and a write of zero changes nothing. A read of address 1 returns zero.
- R8: An acknowledge of line N clears pending bit N when line N is edge-sensitive and does not touch any other bit, and has no effect on a level-sensitive line.
- R9: `new_pending_o` is high for exactly the cycles in which the pending vector shows at least one bit that was clear in the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NLINES | Raw interrupt request lines, active high |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 2 | Register word address: 0 pending, 1 trigger, 2 sense |
| reg_wdata | input | NLINES | Register write data |
| reg_rdata | output | NLINES | Register read data for `reg_addr`, combinational |
| ack_valid | input | 1 | Acknowledge strobe from the arbiter |
| ack_line | input | IDW | Line number being acknowledged |
| pending_o | output | NLINES | Pending vector to the arbiter |
| raw_o | output | NLINES | Raw request lines as sampled on the last edge |
| new_pending_o | output | 1 | One-cycle pulse when new pending bits appear |

## Verification
The hardest case to reach is a pending line that is still requesting when software tries to clear it: an edge line held high must stay clear after the clear and must not latch again until its wire drops and rises, while a level line held high must refuse the clear and an acknowledge. The stimulus holds the request wire steady across the register write and the acknowledge strobe, checks the pending vector on the next edge and on the edge after that, and then drops and raises the wire to show that only a new transition sets the edge line again. A mixed write is also applied in which edge and level lines are high together, so that a single write clears some bits and leaves others set.

// File: rtl/irq_capture_bank.sv
module irq_capture_bank #(
  parameter int NLINES = 32,
  localparam int IDW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_in,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [NLINES-1:0] reg_wdata,
  output logic [NLINES-1:0] reg_rdata,
  input  logic              ack_valid,
  input  logic [IDW-1:0]    ack_line,
  output logic [NLINES-1:0] pending_o,
  output logic [NLINES-1:0] raw_o,
  output logic              new_pending_o
);

  localparam logic [1:0] A_PEND  = 2'd0;
  localparam logic [1:0] A_TRIG  = 2'd1;
  localparam logic [1:0] A_SENSE = 2'd2;
  localparam logic [NLINES-1:0] ONE = {{(NLINES-1){1'b0}}, 1'b1};

  logic [NLINES-1:0] pend_q, raw_q, sense_q;
  logic [NLINES-1:0] hw_set, hw_clr, sw_keep, trig_set, ack_clr, pend_d;
  logic              new_q;

  // level lines latch while high; edge lines only on a low-to-high step
  assign hw_set   = irq_in & (sense_q | ~raw_q);
  assign hw_clr   = sense_q & raw_q & ~irq_in;
  assign sw_keep  = (reg_wr && reg_addr == A_PEND) ? (reg_wdata | (irq_in & sense_q)) : '1;
  assign trig_set = (reg_wr && reg_addr == A_TRIG) ? (reg_wdata & (~reg_wdata + ONE)) : '0;
  assign ack_clr  = ack_valid ? ((ONE << ack_line) & ~sense_q) : '0;

  assign pend_d = (pend_q & ~hw_clr & sw_keep & ~ack_clr) | hw_set | trig_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      raw_q   <= '0;
      sense_q <= '0;
      new_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      raw_q  <= irq_in;
      new_q  <= |(pend_d & ~pend_q);
      if (reg_wr && reg_addr == A_SENSE) sense_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      A_PEND:  reg_rdata = pend_q;
      A_SENSE: reg_rdata = sense_q;
      default: reg_rdata = '0;
    endcase
  end

  assign pending_o     = pend_q;
  assign raw_o         = raw_q;
  assign new_pending_o = new_q;

  a_r3_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr && reg_addr == A_PEND) && !ack_valid)
      |=> (($past(pend_q & ~sense_q) & ~pend_q) == '0));

  a_r5_level_active_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_q & sense_q & irq_in))
      |=> (($past(pend_q & sense_q & irq_in) & ~pend_q) == '0));

  a_r9_pulse_on_new: assert property (@(posedge clk) disable iff (!rst_n)
    new_pending_o |-> ((pending_o & ~$past(pending_o)) != '0));

  a_r9_new_gives_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending_o & ~$past(pending_o)) != '0) |-> new_pending_o);

endmodule

// File: tb/irq_capture_bank_tb_top.sv
`timescale 1ns/1ps
module irq_capture_bank_tb_top;

  localparam int N = 32;
  localparam int IDW = 5;

  typedef struct {
    string       req;
    int          kind;
    logic [31:0] exp;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [N-1:0]  reg_wdata = '0;
  logic [N-1:0]  reg_rdata;
  logic          ack_valid = 1'b0;
  logic [IDW-1:0] ack_line = '0;
  logic [N-1:0]  pending_o, raw_o;
  logic          new_pending_o;

  item_t sb_q[$];
  event  go;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;

  always #2.5 clk = ~clk;

  irq_capture_bank #(.NLINES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ack_valid(ack_valid), .ack_line(ack_line),
    .pending_o(pending_o), .raw_o(raw_o), .new_pending_o(new_pending_o)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(go);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = pending_o;
          1: act = raw_o;
          2: act = reg_rdata;
          default: act = {31'b0, new_pending_o};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%08h expected=%08h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic push(input string r, input int k, input logic [31:0] e);
    item_t it;
    it.req = r; it.kind = k; it.exp = e;
    sb_q.push_back(it);
  endtask

  task automatic flush();
    ->go;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    reg_wr = 1'b0;
    ack_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_addr = 2'd0;
  endtask

  task automatic ack(input int line);
    ack_valid = 1'b1; ack_line = IDW'(line);
    tick();
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    reg_addr = 2'd0;
    push("R1 pending", 0, 0); push("R1 raw", 1, 0); push("R1 pulse", 3, 0); push("R1 rd pend", 2, 0);
    flush();
    reg_addr = 2'd2; push("R1 rd sense", 2, 0); flush();

    // R2 sense write: lines 4..7 level
    wr(2'd2, 32'h0000_00F0);
    reg_addr = 2'd2; push("R2 sense readback", 2, 32'h0000_00F0); flush();
    reg_addr = 2'd0;

    // R3 edge line 0
    irq_in = 32'h1; tick();
    push("R3 edge latch", 0, 32'h1); push("R9 pulse", 3, 1); push("R2 raw", 1, 32'h1); flush();
    tick();
    push("R9 no pulse", 3, 0); push("R3 still pend", 0, 32'h1); flush();
    irq_in = 0; tick();
    push("R3 edge held", 0, 32'h1); push("R2 raw low", 1, 0); flush();
    wr(2'd0, 32'hFFFF_FFFE);
    push("R6 sw clear edge", 0, 0); flush();

    // R4 edge held high after clear
    irq_in = 32'h2; tick();
    push("R4 latch", 0, 32'h2); flush();
    wr(2'd0, 32'h0);
    push("R4 cleared", 0, 0); flush();
    tick(); tick();
    push("R4 no relatch", 0, 0); push("R9 quiet", 3, 0); flush();
    irq_in = 0; tick();
    irq_in = 32'h2; tick();
    push("R4 new transition", 0, 32'h2); flush();
    irq_in = 0; wr(2'd0, 32'h0);
    push("R4 cleanup", 0, 0); flush();

    // R5 level line 4
    irq_in = 32'h10; tick();
    push("R5 level latch", 0, 32'h10); push("R9 pulse level", 3, 1); flush();
    wr(2'd0, 32'h0);
    push("R6 level protected", 0, 32'h10); flush();
    ack(4);
    push("R8 level ack ignored", 0, 32'h10); flush();
    irq_in = 0; tick();
    push("R5 level fall clears", 0, 0); flush();

    // R8 edge ack
    irq_in = 32'h4; tick();
    push("R8 setup", 0, 32'h4); flush();
    irq_in = 0; ack(3);
    push("R8 other line untouched", 0, 32'h4); flush();
    ack(2);
    push("R8 edge ack clears", 0, 0); flush();

    // R7 software trigger
    wr(2'd1, 32'h0000_0A08);
    push("R7 lowest bit only", 0, 32'h8); push("R9 pulse trig", 3, 1); flush();
    reg_addr = 2'd1; push("R7 read zero", 2, 0); flush(); reg_addr = 2'd0;
    push("R6 read pend", 2, 32'h8); flush();
    wr(2'd1, 32'h0);
    push("R7 zero write", 0, 32'h8); flush();
    wr(2'd0, 32'h0);
    push("R7 cleanup", 0, 0); flush();
    wr(2'd1, 32'h0000_0020);
    push("R7 trig level line", 0, 32'h20); flush();
    tick();
    push("R7 level trig persists", 0, 32'h20); flush();
    wr(2'd0, 32'h0);
    push("R6 level low clears", 0, 0); flush();

    // R6 mixed edge and level
    irq_in = 32'h31; tick();
    push("R6 mixed latch", 0, 32'h31); flush();
    wr(2'd0, 32'h0);
    push("R6 mixed clear", 0, 32'h30); flush();
    irq_in = 0; tick();
    push("R5 mixed fall", 0, 0); flush();

    // wide edge pattern
    irq_in = 32'hFFFF_0000; tick();
    push("R3 upper edges", 0, 32'hFFFF_0000); push("R2 raw wide", 1, 32'hFFFF_0000); flush();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule